// File: doc/BRIEF.md
# Three-Phase Output Enable and Shoot-Through Guard

This block sits between a three-phase PWM/dead-time generator and the six motor-drive pads. Each phase has a high-side and a low-side switch. The block registers the six raw phase levels and passes them to the pads. It also holds an output-enable latch that controls all six pad drivers together. When the drive function is on and output is disabled, every pad is released to high impedance.

The block watches each phase for both switches being active at once. This shoot-through condition raises a sticky detect flag that only hardware can set. When the lockout bit is set, the same condition forces both switches of the offending phase inactive and drops the output-enable latch. A falling edge on the active-low external fault pin also drops the latch. The fault pin is first brought into the clock domain by a synchroniser.

Software reaches the three control bits through a single write strobe. The output-enable and lockout bits load directly from the write. The detect flag clears only when the same write also clears the lockout bit.

Top module: `tri_phase_guard`

## Requirements
- R1: Pad output-enables are all high only while the function enable is 1 and the output-enable latch is 1; otherwise all six are low (high impedance).
- R2: After reset the output-enable latch, lockout bit and detect flag read 0, and all six pad levels are 0.
- R3: A write loads the output-enable latch and the lockout bit from the written values, visible one cycle after the write strobe.
- R4: A high-to-low transition of the fault pin, seen after a two-flop synchroniser, clears the output-enable latch on the third rising edge after the low level is first sampled.
- R5: While the function is enabled and lockout is 1, a registered phase with both sides at 1 clears the output-enable latch on the next edge.
- R6: Pad levels follow the raw phase inputs one cycle late. While lockout is 1, a phase whose two raw sides are both 1 drives both of its pad levels to 0. While lockout is 0, such a phase is passed through unchanged.
- R7: While the function is enabled, any registered phase with both sides at 1 sets the detect flag on the next edge. Writing 1 to the detect flag never sets it.
- R8: A write with detect value 0 clears the detect flag only if the same write has lockout value 0. With lockout value 1, the flag stays set.
- R9: A shutdown event (fault edge or locked-out shoot-through) in the same cycle as a write of 1 to the output-enable latch leaves the latch at 0.
- R10: A hardware detect event in the same cycle as a valid clear write leaves the detect flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| raw_hi_i | input | 3 | Raw high-side phase levels, active high |
| raw_lo_i | input | 3 | Raw low-side phase levels, active high |
| func_en_i | input | 1 | Three-phase drive function enable |
| wr_en_i | input | 1 | Software write strobe |
| wr_oe_i | input | 1 | Written output-enable value |
| wr_lock_i | input | 1 | Written lockout-enable value |
| wr_det_i | input | 1 | Written detect-flag value (only 0 acts) |
| fault_ni | input | 1 | External fault pin, active low, asynchronous |
| pad_hi_o | output | 3 | High-side pad levels |
| pad_lo_o | output | 3 | Low-side pad levels |
| pad_hi_oe_o | output | 3 | High-side pad driver enables |
| pad_lo_oe_o | output | 3 | Low-side pad driver enables |
| oe_o | output | 1 | Output-enable latch status |
| lock_o | output | 1 | Lockout-enable status |
| det_o | output | 1 | Shoot-through detect flag |

## Verification
The bench sweeps all 64 raw phase patterns with lockout off, with lockout on, and with the function disabled. It compares pads, pad enables and status each cycle against a cycle model computed from the requirements. Any shoot-through gating error or off-by-one in register latency shows up as a wrong pad level. It also targets the priority corners. A write of 1 to the enable that lands with a fault edge or a locked shoot-through must lose, or the pads keep driving during a fault. A detect clear written with lockout still 1 must be ignored, or the flag is lost. A clear that lands with a new detect event must also lose, or the flag is lost. The fault-edge timing is checked cycle-exactly, so a synchroniser with the wrong depth or an edge detector working on the raw pin is reported.

// File: rtl/tri_phase_guard_pkg.sv
package tri_phase_guard_pkg;
  localparam int unsigned NUM_PHASES  = 3;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic oe;
    logic lock;
    logic det;
  } sw_wr_t;
endpackage

// File: rtl/tpg_fault_sync.sv
module tpg_fault_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic fall_o
);
  localparam int unsigned LEN = STAGES + 1;

  logic [LEN-1:0] chain_q;

  // idle-high reset so no edge is seen coming out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[LEN-2:0], pin_ni};
  end

  assign fall_o = chain_q[LEN-1] & ~chain_q[LEN-2];
endmodule

// File: rtl/tpg_phase_gate.sv
module tpg_phase_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_i,
  input  logic lo_i,
  input  logic lock_i,
  output logic hi_o,
  output logic lo_o,
  output logic ov_o
);
  logic hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_i;
      lo_q <= lo_i;
    end
  end

  assign ov_o = hi_q & lo_q;
  assign hi_o = hi_q & ~(lock_i & ov_o);
  assign lo_o = lo_q & ~(lock_i & ov_o);

  assert_no_shoot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |-> !(hi_o && lo_o));
endmodule

// File: rtl/tpg_ctrl.sv
module tpg_ctrl
  import tri_phase_guard_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   wr_en_i,
  input  sw_wr_t wr_i,
  input  logic   ov_any_i,
  input  logic   fall_i,
  output logic   oe_o,
  output logic   lock_o,
  output logic   det_o
);
  logic oe_q, lock_q, det_q;
  logic shut, det_clr;

  assign shut    = fall_i | (lock_q & ov_any_i);
  assign det_clr = wr_en_i & ~wr_i.det & ~wr_i.lock;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      lock_q <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      // shutdown beats a same-cycle set
      if (shut)         oe_q <= 1'b0;
      else if (wr_en_i) oe_q <= wr_i.oe;
      if (wr_en_i)      lock_q <= wr_i.lock;
      // hardware set beats a same-cycle clear
      if (ov_any_i)     det_q <= 1'b1;
      else if (det_clr) det_q <= 1'b0;
    end
  end

  assign oe_o   = oe_q;
  assign lock_o = lock_q;
  assign det_o  = det_q;

  assert_fault_clears_oe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |=> !oe_q);
  assert_lock_trip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && ov_any_i) |=> !oe_q);
  assert_det_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_any_i |=> det_q);
  assert_det_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_q && !(wr_en_i && !wr_i.det && !wr_i.lock)) |=> det_q);
endmodule

// File: rtl/tri_phase_guard.sv
module tri_phase_guard
  import tri_phase_guard_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PHASES-1:0] raw_hi_i,
  input  logic [NUM_PHASES-1:0] raw_lo_i,
  input  logic                  func_en_i,
  input  logic                  wr_en_i,
  input  logic                  wr_oe_i,
  input  logic                  wr_lock_i,
  input  logic                  wr_det_i,
  input  logic                  fault_ni,
  output logic [NUM_PHASES-1:0] pad_hi_o,
  output logic [NUM_PHASES-1:0] pad_lo_o,
  output logic [NUM_PHASES-1:0] pad_hi_oe_o,
  output logic [NUM_PHASES-1:0] pad_lo_oe_o,
  output logic                  oe_o,
  output logic                  lock_o,
  output logic                  det_o
);
  logic [NUM_PHASES-1:0] ov;
  logic                  fall, oe, lock;
  sw_wr_t                wr;

  assign wr = '{oe: wr_oe_i, lock: wr_lock_i, det: wr_det_i};

  tpg_fault_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_ni(fault_ni),
    .fall_o(fall)
  );

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    tpg_phase_gate u_gate (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .hi_i  (raw_hi_i[p]),
      .lo_i  (raw_lo_i[p]),
      .lock_i(lock),
      .hi_o  (pad_hi_o[p]),
      .lo_o  (pad_lo_o[p]),
      .ov_o  (ov[p])
    );
  end

  tpg_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wr_i    (wr),
    .ov_any_i(func_en_i & (|ov)),
    .fall_i  (fall),
    .oe_o    (oe),
    .lock_o  (lock),
    .det_o   (det_o)
  );

  assign pad_hi_oe_o = {NUM_PHASES{func_en_i & oe}};
  assign pad_lo_oe_o = {NUM_PHASES{func_en_i & oe}};
  assign oe_o        = oe;
  assign lock_o      = lock;

  assert_hiz_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (pad_hi_oe_o == '0 && pad_lo_oe_o == '0));
endmodule

// File: tb/tri_phase_guard_tb.sv
module tri_phase_guard_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] raw_hi = '0, raw_lo = '0;
  logic       func_en = 1'b0, wr_en = 1'b0, wr_oe = 1'b0, wr_lock = 1'b0, wr_det = 1'b0;
  logic       fault_n = 1'b1;
  logic [2:0] pad_hi, pad_lo, pad_hi_oe, pad_lo_oe;
  logic       oe, lock, det;

  int errors = 0, checks = 0;

  // bench cycle model
  logic [2:0] m_hi = '0, m_lo = '0;
  logic       m_oe = 0, m_lock = 0, m_det = 0, m_s1 = 1, m_s2 = 1, m_s3 = 1;

  always #5 clk = ~clk;

  tri_phase_guard u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .raw_hi_i(raw_hi), .raw_lo_i(raw_lo),
    .func_en_i(func_en), .wr_en_i(wr_en), .wr_oe_i(wr_oe), .wr_lock_i(wr_lock),
    .wr_det_i(wr_det), .fault_ni(fault_n), .pad_hi_o(pad_hi), .pad_lo_o(pad_lo),
    .pad_hi_oe_o(pad_hi_oe), .pad_lo_oe_o(pad_lo_oe), .oe_o(oe), .lock_o(lock), .det_o(det)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [2:0] ov, e_hi, e_lo, e_oe;
    ov   = m_hi & m_lo;
    e_hi = m_hi & ~({3{m_lock}} & ov);
    e_lo = m_lo & ~({3{m_lock}} & ov);
    e_oe = {3{func_en & m_oe}};
    check("R6 pad levels", {10'd0, pad_hi, pad_lo}, {10'd0, e_hi, e_lo});
    check("R1 pad enables", {10'd0, pad_hi_oe, pad_lo_oe}, {10'd0, e_oe, e_oe});
    check("R3/R7 status", {13'd0, oe, lock, det}, {13'd0, m_oe, m_lock, m_det});
  endtask

  // drive after negedge, model one edge, check at next negedge
  task automatic step(logic [2:0] hi, logic [2:0] lo, logic f, logic we,
                      logic woe, logic wl, logic wd);
    logic any, fall, shut;
    raw_hi = hi; raw_lo = lo; fault_n = f;
    wr_en = we; wr_oe = woe; wr_lock = wl; wr_det = wd;
    @(posedge clk);
    any  = func_en & (|(m_hi & m_lo));
    fall = m_s3 & ~m_s2;
    shut = fall | (m_lock & any);
    if (shut) m_oe = 0; else if (we) m_oe = woe;
    if (we) m_lock = wl;
    if (any) m_det = 1; else if (we && !wd && !wl) m_det = 0;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = f;
    m_hi = hi; m_lo = lo;
    @(negedge clk);
    wr_en = 0;
    check_all();
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all();                              // R2 reset state
    rst_ni = 1'b1;
    func_en = 1'b1;
    step(0, 0, 1, 1, 1, 0, 0);                // R3 enable, lockout off
    for (int v = 0; v < 64; v++)              // R6 pass-through, R7 detect
      step(v[5:3], v[2:0], 1, 0, 0, 0, 0);
    step(0, 0, 1, 1, 1, 0, 0);                // R8 clear with lock 0
    step(0, 0, 1, 1, 1, 0, 1);                // R7 write 1 ignored
    for (int v = 0; v < 64; v++) begin        // R5/R6 lockout sweep
      step(0, 0, 1, 1, 1, 1, 1);
      step(v[5:3], v[2:0], 1, 0, 0, 0, 0);
      step(0, 0, 1, 0, 0, 0, 0);
    end
    step(0, 0, 1, 1, 1, 1, 0);                // R8 clear ignored with lock 1
    step(0, 0, 1, 1, 1, 0, 0);                // R8 clear
    step(3'b010, 3'b010, 1, 1, 1, 1, 0);      // overlap captured, lock on
    step(0, 0, 1, 1, 1, 1, 0);                // R9 set loses to lock trip
    step(0, 0, 1, 1, 1, 1, 0);
    step(0, 0, 0, 1, 1, 0, 0);                // R4 fault falls
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0, 0);                // R9 set lands on fault edge
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 1, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    step(3'b001, 3'b001, 1, 0, 0, 0, 0);      // R10 detect vs clear
    step(0, 0, 1, 1, 1, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    func_en = 1'b0;                           // R1 function off
    for (int v = 0; v < 64; v++)
      step(v[5:3], v[2:0], 1, 0, 0, 0, 0);
    func_en = 1'b1;
    step(0, 0, 1, 1, 0, 0, 0);                // R1 oe 0 with function on
    step(3'b101, 3'b010, 1, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule